// File: doc/BRIEF.md
# Two-Bank Channel Framebuffer

This block holds the lighting frame for one channel: 512 byte-wide slots, one full universe, stored twice so that the channel owns two banks of 512 bytes. At any time one bank is the control bank. The module-facing side reads and writes it through the control port. The other bank is the live bank, which the output side reads through its own port. Both ports work in the same cycle without waiting for each other.

When a new frame is complete in the control bank, a one-cycle swap strobe exchanges the roles of the two banks. The exchange happens only on a clock edge where neither port is active. This keeps a frame from being torn while it is being written or read out. A swap requested while a port is busy is held and applied at the first idle edge. The active-bank indicator shows which physical bank currently plays the control role. Reset returns the indicator to bank 0 and does not touch the stored bytes.

Top module: `fbuf_dual_bank`

## Requirements
- R1: A control write (ctl_en=1, ctl_we=1) stores ctl_wdata at slot ctl_addr of the current control bank. A control read (ctl_en=1, ctl_we=0) returns that slot on ctl_rdata one cycle later, sampled after the next rising edge.
- R2: A live read (live_en=1) returns slot live_addr of the bank that is not the control bank, with the same one-cycle latency.
- R3: While rst_n is low, ctl_bank is 0 and both read-data outputs are 0. Stored bytes survive reset: after reset, bank 0 data is readable on the control port and bank 1 data is readable on the live port.
- R4: swap_req on an edge where ctl_en and live_en are both low toggles ctl_bank at that edge. Data written through the control port then appears on the live port.
- R5: swap_req on an edge where ctl_en or live_en is high leaves ctl_bank unchanged. The toggle happens at the first later edge where both are low.
- R6: Any number of swap_req pulses during one busy stretch cause exactly one toggle, and a second idle edge causes no further toggle.
- R7: ctl_rdata changes only after a control read, so it holds through idle cycles and write cycles. live_rdata changes only after a live read.
- R8: A control write never alters the live bank. A live read of the same slot still returns the earlier frame.
- R9: All 9 address bits are decoded: slots 0 and 511 and the slots in between hold independent values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_en | input | 1 | Control port access this cycle |
| ctl_we | input | 1 | Control access is a write when 1, a read when 0 |
| ctl_addr | input | 9 | Control slot address |
| ctl_wdata | input | 8 | Control write byte |
| ctl_rdata | output | 8 | Control read byte, one cycle after the read |
| live_en | input | 1 | Live port read this cycle |
| live_addr | input | 9 | Live slot address |
| live_rdata | output | 8 | Live read byte, one cycle after the read |
| swap_req | input | 1 | One-cycle request to exchange bank roles |
| ctl_bank | output | 1 | Physical bank currently in the control role |

## Verification
The bench targets the swap timing. It pulses swap on an idle edge, while only the live port is busy, and repeatedly while the control port is busy. A design that toggles during an access would fail these checks, and so would one that drops a deferred request or toggles once per pulse. A design that does either would tear a frame or leave the banks in the wrong roles. The bench also writes the control bank while reading the same slot live. A design that mapped both ports onto one bank would show the new byte on the output side. It checks read-data hold across idle and write cycles, and checks that reset keeps bank contents. A design that reset the memory or refreshed the data register on every cycle would be caught there.

// File: rtl/fbuf_pkg.sv
package fbuf_pkg;

  typedef enum logic {
    BANK_0 = 1'b0,
    BANK_1 = 1'b1
  } bank_e;

  function automatic bank_e other_bank(input bank_e b);
    return (b == BANK_0) ? BANK_1 : BANK_0;
  endfunction

endpackage

// File: rtl/fbuf_swap_ctl.sv
module fbuf_swap_ctl
  import fbuf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  swap_req,
  input  logic  ctl_act,
  input  logic  live_act,
  output bank_e ctl_bank,
  output logic  swap_pend
);

  logic busy;
  logic want;
  logic swap_fire;

  assign busy      = ctl_act | live_act;
  assign want      = swap_req | swap_pend;
  assign swap_fire = want & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_bank  <= BANK_0;
      swap_pend <= 1'b0;
    end else begin
      if (swap_fire) ctl_bank <= other_bank(ctl_bank);
      swap_pend <= want & busy;
    end
  end

  AST_SWAP_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_bank != $past(ctl_bank)) |-> !$past(busy)); // R5
  AST_IDLE_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_req && !busy) |=> (ctl_bank != $past(ctl_bank))); // R4
  AST_DEFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_req && busy) |=> (ctl_bank == $past(ctl_bank))); // R5
  AST_PEND_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_pend && !busy) |=> !swap_pend); // R6

endmodule

// File: rtl/fbuf_store.sv
module fbuf_store
  import fbuf_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  bank_e             wr_bank,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_en,
  input  bank_e             rd_bank [2],
  input  logic [ADDR_W-1:0] rd_addr [2],
  output logic [DATA_W-1:0] rd_q    [2]
);

  localparam int DEPTH = 2 << ADDR_W;

  function automatic logic [ADDR_W:0] slot_index(input bank_e b,
                                                 input logic [ADDR_W-1:0] a);
    return {logic'(b), a};
  endfunction

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[slot_index(wr_bank, wr_addr)] <= wr_data;
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    always_ff @(posedge clk) begin
      if (!rst_n)        rd_q[p] <= '0;
      else if (rd_en[p]) rd_q[p] <= mem[slot_index(rd_bank[p], rd_addr[p])];
    end
  end

endmodule

// File: rtl/fbuf_dual_bank.sv
module fbuf_dual_bank
  import fbuf_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_en,
  input  logic              ctl_we,
  input  logic [ADDR_W-1:0] ctl_addr,
  input  logic [DATA_W-1:0] ctl_wdata,
  output logic [DATA_W-1:0] ctl_rdata,
  input  logic              live_en,
  input  logic [ADDR_W-1:0] live_addr,
  output logic [DATA_W-1:0] live_rdata,
  input  logic              swap_req,
  output logic              ctl_bank
);

  bank_e             cur_bank;
  logic              swap_pend;
  logic              ctl_rd;
  logic              ctl_wr;
  logic [1:0]        rd_en;
  bank_e             rd_bank [2];
  logic [ADDR_W-1:0] rd_addr [2];
  logic [DATA_W-1:0] rd_q    [2];

  assign ctl_rd = ctl_en & ~ctl_we;
  assign ctl_wr = ctl_en & ctl_we;

  fbuf_swap_ctl u_swap (
    .clk       (clk),
    .rst_n     (rst_n),
    .swap_req  (swap_req),
    .ctl_act   (ctl_en),
    .live_act  (live_en),
    .ctl_bank  (cur_bank),
    .swap_pend (swap_pend)
  );

  assign rd_en      = {live_en, ctl_rd};
  assign rd_bank[0] = cur_bank;
  assign rd_bank[1] = other_bank(cur_bank);
  assign rd_addr[0] = ctl_addr;
  assign rd_addr[1] = live_addr;

  fbuf_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ctl_wr),
    .wr_bank (cur_bank),
    .wr_addr (ctl_addr),
    .wr_data (ctl_wdata),
    .rd_en   (rd_en),
    .rd_bank (rd_bank),
    .rd_addr (rd_addr),
    .rd_q    (rd_q)
  );

  assign ctl_rdata  = rd_q[0];
  assign live_rdata = rd_q[1];
  assign ctl_bank   = logic'(cur_bank);

  AST_CTL_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rd |=> $stable(ctl_rdata)); // R7
  AST_LIVE_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !live_en |=> $stable(live_rdata)); // R7
  AST_PEND_CLEAR_ON_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_bank != $past(ctl_bank)) |-> !swap_pend); // R6

endmodule

// File: tb/fbuf_dual_bank_test.sv
module fbuf_dual_bank_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctl_en, ctl_we, live_en, swap_req;
  logic [8:0] ctl_addr, live_addr;
  logic [7:0] ctl_wdata;
  logic [7:0] ctl_rdata, live_rdata;
  logic       ctl_bank;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  fbuf_dual_bank uut (
    .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .ctl_we(ctl_we),
    .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .live_en(live_en), .live_addr(live_addr), .live_rdata(live_rdata),
    .swap_req(swap_req), .ctl_bank(ctl_bank)
  );

  // {address, data}
  localparam logic [16:0] VEC [8] = '{
    {9'd0,   8'h11}, {9'd511, 8'hEE}, {9'd1,   8'h22}, {9'd256, 8'h5A},
    {9'd255, 8'hA5}, {9'd128, 8'h3C}, {9'd510, 8'hC3}, {9'd7,   8'h00}
  };

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle_all();
    ctl_en = 0; ctl_we = 0; live_en = 0; swap_req = 0;
  endtask

  task automatic cycle();
    @(posedge clk); #1;
  endtask

  task automatic ctl_write(input logic [8:0] a, input logic [7:0] d);
    @(negedge clk);
    idle_all(); ctl_en = 1; ctl_we = 1; ctl_addr = a; ctl_wdata = d;
    cycle(); idle_all();
  endtask

  task automatic ctl_read(input logic [8:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    idle_all(); ctl_en = 1; ctl_addr = a;
    cycle(); chk(req, {8'h0, ctl_rdata}, {8'h0, exp}); idle_all();
  endtask

  task automatic live_read(input logic [8:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    idle_all(); live_en = 1; live_addr = a;
    cycle(); chk(req, {8'h0, live_rdata}, {8'h0, exp}); idle_all();
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_all(); rst_n = 0;
    cycle(); cycle();
    chk("R3 bank", {15'h0, ctl_bank}, 16'h0);
    chk("R3 ctl_rdata", {8'h0, ctl_rdata}, 16'h0);
    chk("R3 live_rdata", {8'h0, live_rdata}, 16'h0);
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] hold;
    rst_n = 0; ctl_addr = 0; live_addr = 0; ctl_wdata = 0;
    idle_all();
    do_reset();

    // R1 R9: table walk into bank 0, then read back
    for (int i = 0; i < 8; i++) ctl_write(VEC[i][16:8], VEC[i][7:0]);
    for (int i = 0; i < 8; i++) ctl_read(VEC[i][16:8], VEC[i][7:0], "R1/R9 ctl readback");

    // R4: idle swap toggles at that edge
    @(negedge clk); idle_all(); swap_req = 1;
    cycle(); idle_all();
    chk("R4 idle swap", {15'h0, ctl_bank}, 16'h1);

    // R2 R4: frame now on live port
    for (int i = 0; i < 8; i++) live_read(VEC[i][16:8], VEC[i][7:0], "R2/R4 live read");

    // R8: writes to control bank do not reach live bank
    for (int i = 0; i < 8; i++) ctl_write(VEC[i][16:8], ~VEC[i][7:0]);
    for (int i = 0; i < 8; i++) begin
      live_read(VEC[i][16:8], VEC[i][7:0], "R8 live untouched");
      ctl_read(VEC[i][16:8], ~VEC[i][7:0], "R1 ctl bank 1");
    end

    // R7: read data holds through idle and write cycles
    ctl_read(9'd256, 8'hA5, "R7 setup");
    hold = ctl_rdata;
    @(negedge clk); idle_all(); ctl_addr = 9'd0; cycle();
    chk("R7 ctl hold idle", {8'h0, ctl_rdata}, {8'h0, hold});
    ctl_write(9'd300, 8'h99);
    chk("R7 ctl hold write", {8'h0, ctl_rdata}, {8'h0, hold});
    live_read(9'd1, 8'h22, "R7 live setup");
    @(negedge clk); idle_all(); live_addr = 9'd511; cycle();
    chk("R7 live hold", {8'h0, live_rdata}, 16'h0022);

    // R5: swap deferred while live port busy
    @(negedge clk); idle_all(); live_en = 1; live_addr = 9'd0; swap_req = 1;
    cycle(); chk("R5 defer 1", {15'h0, ctl_bank}, 16'h1);
    swap_req = 0;
    cycle(); chk("R5 defer 2", {15'h0, ctl_bank}, 16'h1);
    cycle(); chk("R5 defer 3", {15'h0, ctl_bank}, 16'h1);
    @(negedge clk); idle_all();
    cycle(); chk("R5 applied on idle", {15'h0, ctl_bank}, 16'h0);

    // R6: multiple requests while control port busy give one toggle
    @(negedge clk); idle_all(); ctl_en = 1; ctl_addr = 9'd0; swap_req = 1;
    for (int k = 0; k < 3; k++) begin
      cycle(); chk("R6 busy hold", {15'h0, ctl_bank}, 16'h0);
    end
    @(negedge clk); idle_all();
    cycle(); chk("R6 single toggle", {15'h0, ctl_bank}, 16'h1);
    cycle(); chk("R6 no second toggle", {15'h0, ctl_bank}, 16'h1);

    // R3: reset keeps memory contents
    do_reset();
    ctl_read(VEC[0][16:8], VEC[0][7:0], "R3 bank0 kept");
    live_read(VEC[0][16:8], ~VEC[0][7:0], "R3 bank1 kept");
    ctl_read(VEC[1][16:8], VEC[1][7:0], "R3/R9 slot 511 kept");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule